// File: doc/BRIEF.md
# Critical-Word Line Fill Sequencer

This block runs the refill of one cache line after a read miss. When a miss is accepted it issues a single line request to a slower memory port. It then takes the returning words in ascending order from word 0 and passes each one straight to the line buffer write port. The word the processor asked for is picked out by its offset within the line. In early-release mode that word goes to the processor in the very cycle it arrives from memory, and the processor stall drops at once while the rest of the line keeps streaming into the buffer. With early release off, the processor waits until the whole line is written and gets its word one cycle later, as a normal cache read would deliver it.

The block holds off every new miss until the current line is complete. It latches the release mode when it accepts the miss. Tag lookup, victim choice and write traffic belong to neighbouring blocks. With a memory that returns its first word 10 cycles after the request and the rest back to back, the full-line mode stalls the processor for 19 cycles. In early-release mode the stall lasts 11 + k cycles for requested word k.

Top module: `line_fill_lt`

## Requirements
- R1: After reset the block is idle: `reqReady` is 1, and `cpuStall`, `memReqValid`, `lineWe` and `cpuValid` are 0.
- R2: A miss is accepted on a clock edge where `missValid` and `reqReady` are both 1. In the next cycle `memReqValid` is 1 for exactly one cycle with `memReqLine` equal to `missAddr[ADDR_W-1:3]`, and `cpuStall` is 1 from that cycle on.
- R3: During a fill each cycle with `memDataValid` high produces `lineWe` = 1 in the same cycle, with `lineWData` = `memData` and `lineWeIdx` counting 0,1,...,7. Exactly 8 writes are made per miss.
- R4: In early-release mode (`loadThrough` = 1 at acceptance), `cpuValid` is 1 with `cpuData` = `memData` in the cycle of the beat whose index equals `missAddr[2:0]`. `cpuStall` is 0 from the next cycle.
- R5: In full-line mode (`loadThrough` = 0 at acceptance), `cpuValid` is 1 in the cycle after the eighth beat and carries the word held from the beat at index `missAddr[2:0]`. `cpuStall` is 0 from the cycle after that. With a 10-cycle first-word latency, the stall lasts 19 cycles.
- R6: Cycles without `memDataValid` inside a fill advance neither the write index nor the forwarding point.
- R7: `reqReady` stays 0 from acceptance until the fill and any delivery complete. A `missValid` offered meanwhile is dropped and starts no new request.
- R8: The release mode is sampled only at acceptance. A change of `loadThrough` during a fill does not alter that fill's timing.
- R9: `memDataValid` while no fill is running causes no `lineWe` and no `cpuValid`.
- R10: Each accepted miss yields exactly one `cpuValid` cycle, and `cpuValid` is only ever 1 while `cpuStall` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | A read miss is offered |
| missAddr | input | ADDR_W | Word address of the miss; low 3 bits select the word in the line |
| loadThrough | input | 1 | 1 = release the processor on the requested word, 0 = after the full line |
| reqReady | output | 1 | Idle and able to accept a miss |
| memReqValid | output | 1 | One-cycle line request to memory |
| memReqLine | output | ADDR_W-3 | Line address of the request |
| memDataValid | input | 1 | A memory word is present |
| memData | input | DATA_W | Memory word |
| lineWe | output | 1 | Line buffer write enable |
| lineWeIdx | output | 3 | Word index written in the line buffer |
| lineWData | output | DATA_W | Line buffer write data |
| cpuValid | output | 1 | Requested word is on `cpuData` |
| cpuData | output | DATA_W | Word returned to the processor |
| cpuStall | output | 1 | Processor must wait |

## Verification
A wrong beat counter would misplace the line buffer write index and the forwarding point together. That shows at the ports within the first beat after it goes wrong, as a wrong `lineWeIdx`, a wrong `cpuData` or a `cpuValid` in the wrong cycle. A bad mode latch or a stuck delivery flag would not touch the write stream. It would show as a stall that ends at the wrong cycle or never ends, and the measured stall length gives it away within one miss. The sweep covers every requested word in both modes, so each forwarding position is checked against cycle counts worked out from the memory timing.

// File: rtl/lfill_pkg.sv
package lfill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_REPLAY
  } fillState_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic capture;   // latch a newly accepted miss
    logic beatTake;  // a memory word is written this cycle
    logic fwdNow;    // forward the incoming word to the processor
    logic replayNow; // return the held word after a full fill
  } fillStrobe_t;
endpackage

// File: rtl/lfill_ctrl.sv
module lfill_ctrl
  import lfill_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        loadThrough,
  input  logic        memDataValid,
  input  logic        idxHit,
  input  logic        idxLast,
  output fillStrobe_t strobe,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        cpuStall
);
  fillState_t state, stateNxt;
  logic modeLt;
  logic delivered;

  always_comb begin
    reqReady         = (state == ST_IDLE);
    memReqValid      = (state == ST_REQ);
    strobe.capture   = missValid && reqReady;
    strobe.beatTake  = (state == ST_FILL) && memDataValid;
    strobe.fwdNow    = strobe.beatTake && idxHit && modeLt;
    strobe.replayNow = (state == ST_REPLAY);
    cpuStall         = (state != ST_IDLE) && !delivered;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:   if (strobe.capture) stateNxt = ST_REQ;
      ST_REQ:    stateNxt = ST_FILL;
      ST_FILL:   if (strobe.beatTake && idxLast) stateNxt = modeLt ? ST_IDLE : ST_REPLAY;
      ST_REPLAY: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeLt    <= 1'b0;
      delivered <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strobe.capture) begin
        modeLt    <= loadThrough;
        delivered <= 1'b0;
      end else if (strobe.fwdNow) begin
        delivered <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lfill_dpath.sv
module lfill_dpath
  import lfill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  fillStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   missAddr,
  input  logic [DATA_W-1:0]   memData,
  output logic                idxHit,
  output logic                idxLast,
  output logic [ADDR_W-OFF_W-1:0] memReqLine,
  output logic                lineWe,
  output logic [OFF_W-1:0]    lineWeIdx,
  output logic [DATA_W-1:0]   lineWData,
  output logic                cpuValid,
  output logic [DATA_W-1:0]   cpuData
);
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(WORDS - 1);

  logic [ADDR_W-OFF_W-1:0] lineReg;
  logic [OFF_W-1:0]        offReg;
  logic [OFF_W-1:0]        beatIdx;
  logic [DATA_W-1:0]       heldWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineReg  <= '0;
      offReg   <= '0;
      beatIdx  <= '0;
      heldWord <= '0;
    end else begin
      if (strobe.capture) begin
        lineReg <= missAddr[ADDR_W-1:OFF_W];
        offReg  <= missAddr[OFF_W-1:0];
        beatIdx <= '0;
      end else if (strobe.beatTake) begin
        beatIdx <= beatIdx + 1'b1;
        if (idxHit) heldWord <= memData;
      end
    end
  end

  always_comb begin
    idxHit     = (beatIdx == offReg);
    idxLast    = (beatIdx == LAST_IDX);
    memReqLine = lineReg;
    lineWe     = strobe.beatTake;
    lineWeIdx  = beatIdx;
    lineWData  = memData;
    cpuValid   = strobe.fwdNow || strobe.replayNow;
    cpuData    = strobe.fwdNow ? memData : heldWord;
  end
endmodule

// File: rtl/line_fill_lt.sv
module line_fill_lt
  import lfill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    missValid,
  input  logic [ADDR_W-1:0]       missAddr,
  input  logic                    loadThrough,
  output logic                    reqReady,
  output logic                    memReqValid,
  output logic [ADDR_W-OFF_W-1:0] memReqLine,
  input  logic                    memDataValid,
  input  logic [DATA_W-1:0]       memData,
  output logic                    lineWe,
  output logic [OFF_W-1:0]        lineWeIdx,
  output logic [DATA_W-1:0]       lineWData,
  output logic                    cpuValid,
  output logic [DATA_W-1:0]       cpuData,
  output logic                    cpuStall
);
  fillStrobe_t strobe;
  logic idxHit;
  logic idxLast;

  lfill_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .missValid(missValid), .loadThrough(loadThrough),
    .memDataValid(memDataValid), .idxHit(idxHit), .idxLast(idxLast),
    .strobe(strobe), .reqReady(reqReady), .memReqValid(memReqValid),
    .cpuStall(cpuStall)
  );

  lfill_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .missAddr(missAddr),
    .memData(memData), .idxHit(idxHit), .idxLast(idxLast),
    .memReqLine(memReqLine), .lineWe(lineWe), .lineWeIdx(lineWeIdx),
    .lineWData(lineWData), .cpuValid(cpuValid), .cpuData(cpuData)
  );
endmodule

// File: rtl/line_fill_lt_checker.sv
module line_fill_lt_checker (
  input logic clk,
  input logic rstN,
  input logic missValid,
  input logic reqReady,
  input logic memReqValid,
  input logic lineWe,
  input logic cpuValid,
  input logic cpuStall,
  input logic memDataValid
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!cpuStall && !lineWe && !cpuValid && !memReqValid));

  a_r2_request_follows: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && reqReady) |=> (memReqValid && cpuStall));

  a_r2_request_single: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  a_r3_write_needs_beat: assert property (@(posedge clk) disable iff (!rstN)
    lineWe |-> memDataValid);

  a_r10_valid_in_stall: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> cpuStall);

  a_r10_release_after_word: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuStall) |-> $past(cpuValid));
endmodule

bind line_fill_lt line_fill_lt_checker u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .reqReady(reqReady),
  .memReqValid(memReqValid), .lineWe(lineWe), .cpuValid(cpuValid),
  .cpuStall(cpuStall), .memDataValid(memDataValid)
);

// File: tb/tb_line_fill_lt.sv
module tb_line_fill_lt;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int FIRST_LAT = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [ADDR_W-1:0] missAddr = '0;
  logic loadThrough = 1'b0;
  logic reqReady, memReqValid;
  logic [ADDR_W-4:0] memReqLine;
  logic memDataValid = 1'b0;
  logic [DATA_W-1:0] memData = '0;
  logic lineWe;
  logic [2:0] lineWeIdx;
  logic [DATA_W-1:0] lineWData;
  logic cpuValid;
  logic [DATA_W-1:0] cpuData;
  logic cpuStall;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_fill_lt dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .loadThrough(loadThrough), .reqReady(reqReady), .memReqValid(memReqValid),
    .memReqLine(memReqLine), .memDataValid(memDataValid), .memData(memData),
    .lineWe(lineWe), .lineWeIdx(lineWeIdx), .lineWData(lineWData),
    .cpuValid(cpuValid), .cpuData(cpuData), .cpuStall(cpuStall)
  );

  function automatic logic [DATA_W-1:0] wordOf(int line, int idx);
    return 32'h5A00_0000 + line * 977 + idx * 32'h0101_0101;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic runTxn(int line, int off, bit lt, bit gap, bit toggle, bit poke);
    int bc[8];
    int sent = 0, weCnt = 0, weBad = 0, cvCnt = 0, cvCycle = -1;
    int cvNoStall = 0, stallCnt = 0, reqExtra = 0;
    logic [DATA_W-1:0] cvData = '0;
    string tag;
    int expCv, expStall;
    tag = gap ? "R6" : (toggle ? "R8" : (lt ? "R4" : "R5"));
    @(negedge clk);
    missValid = 1'b1;
    missAddr = ADDR_W'((line << 3) | off);
    loadThrough = lt;
    #1;
    chk(reqReady == 1'b1 && cpuStall == 1'b0, "R7", "ready before accept", reqReady, 1);
    @(negedge clk);
    for (int t = 0; t < 40; t++) begin
      if (t > 0) @(negedge clk);
      missValid = 1'b0;
      memDataValid = 1'b0;
      if (toggle && t == 3) loadThrough = !lt;
      if (poke && t == 5) begin
        missValid = 1'b1;
        missAddr = ADDR_W'(((line + 1) << 3) | off);
      end
      if (t >= FIRST_LAT && sent < 8 && !(gap && t == FIRST_LAT + 3)) begin
        memDataValid = 1'b1;
        memData = wordOf(line, sent);
        bc[sent] = t;
        sent++;
      end
      #1;
      if (t == 0) begin
        chk(memReqValid == 1'b1, "R2", "request pulse", memReqValid, 1);
        chk(memReqLine == (ADDR_W-3)'(line), "R2", "request line", memReqLine, line);
        chk(cpuStall == 1'b1, "R2", "stall on accept", cpuStall, 1);
      end else if (memReqValid) begin
        reqExtra++;
      end
      if (poke && t == 5) chk(reqReady == 1'b0, "R7", "ready during fill", reqReady, 0);
      if (cpuStall) stallCnt++;
      if (lineWe) begin
        if (lineWeIdx != 3'(weCnt) || lineWData != wordOf(line, weCnt) || !memDataValid) weBad++;
        weCnt++;
      end
      if (cpuValid) begin
        cvCnt++;
        cvCycle = t;
        cvData = cpuData;
        if (!cpuStall) cvNoStall++;
      end
    end
    memDataValid = 1'b0;
    missValid = 1'b0;
    loadThrough = lt;
    expCv    = lt ? bc[off] : bc[7] + 1;
    expStall = lt ? bc[off] + 1 : bc[7] + 2;
    chk(weCnt == 8, "R3", "write count", weCnt, 8);
    chk(weBad == 0, gap ? "R6" : "R3", "write index/data mismatches", weBad, 0);
    chk(cvCnt == 1, "R10", "deliveries per miss", cvCnt, 1);
    chk(cvNoStall == 0, "R10", "delivery outside stall", cvNoStall, 0);
    chk(cvData == wordOf(line, off), tag, "returned word", cvData, wordOf(line, off));
    chk(cvCycle == expCv, tag, "delivery cycle", cvCycle, expCv);
    chk(stallCnt == expStall, tag, "stall cycles", stallCnt, expStall);
    if (!lt && !gap && !toggle) chk(stallCnt == 19, "R5", "full-line penalty", stallCnt, 19);
    chk(reqExtra == 0, "R7", "extra requests", reqExtra, 0);
    chk(reqReady == 1'b1 && cpuStall == 1'b0, "R7", "ready after fill", reqReady, 1);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    chk(cpuStall == 1'b0 && memReqValid == 1'b0, "R1", "reset stall/request", cpuStall, 0);
    chk(lineWe == 1'b0 && cpuValid == 1'b0, "R1", "reset writes", lineWe, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int m = 0; m < 2; m++)
      for (int o = 0; o < 8; o++)
        runTxn(100 + m * 8 + o, o, bit'(m), 1'b0, 1'b0, 1'b0);

    runTxn(300, 5, 1'b1, 1'b1, 1'b0, 1'b0);
    runTxn(301, 2, 1'b0, 1'b1, 1'b0, 1'b0);
    runTxn(302, 6, 1'b1, 1'b0, 1'b1, 1'b0);
    runTxn(303, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    runTxn(304, 0, 1'b1, 1'b0, 1'b0, 1'b1);
    runTxn(305, 7, 1'b0, 1'b0, 1'b0, 1'b1);

    // R9: a stray beat while idle
    @(negedge clk);
    memDataValid = 1'b1;
    memData = 32'hDEAD_BEEF;
    #1;
    chk(lineWe == 1'b0, "R9", "idle beat write", lineWe, 0);
    chk(cpuValid == 1'b0, "R9", "idle beat delivery", cpuValid, 0);
    @(negedge clk);
    memDataValid = 1'b0;
    #1;
    chk(cpuStall == 1'b0 && reqReady == 1'b1, "R9", "idle after stray beat", cpuStall, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule